// File: doc/BRIEF.md
# Thermal Threshold Event and Interrupt Unit

This unit watches the most recent 12-bit temperature code from each sensor channel and turns it into events. The code falls as the die heats, so "hot" always means a numerically small code. Each channel has three event sources. A hot alarm fires once when the code reaches its alarm threshold. It re-arms only after the code has climbed back above a separate, cooler hysteresis code. A shutdown event fires whenever an update lands at or below the shutdown threshold. A data-ready event fires on every update.

Events collect in a sticky status word. Software clears bits by writing ones to them, so writing back a value just read clears exactly the events it saw. A single interrupt line is high while any status bit is set whose enable bit is also set. Up to three channels are supported; the parameter `NUM_CH` selects how many are live. A channel at or above `NUM_CH` never raises an event, and writes to its control words are dropped.

Each live channel runs a two-state alarm machine:
- `ALM_ARMED`: the alarm may fire. Transition *trip*: an update with code <= hot threshold sets the alarm bit and moves to `ALM_TRIPPED`.
- `ALM_TRIPPED`: the alarm cannot fire. Transition *release*: an update with code > hysteresis threshold moves back to `ALM_ARMED` without an event.
- Any other update keeps the machine in its current state.

Top module: `thm_irq_unit`

## Requirements
- R1: After reset, the status word is 0, the interrupt is low, all enables and thresholds are 0, and every alarm machine is in `ALM_ARMED`.
- R2: An update (`code_vld_i[i]` high for one cycle) on a live channel i sets status bit 8+i. The change is visible right after the clock edge that samples the update.
- R3: In `ALM_ARMED`, an update with code <= hot threshold sets status bit i and enters `ALM_TRIPPED`. The comparison includes equality.
- R4: In `ALM_TRIPPED`, no alarm event is raised. Only an update with code strictly greater than the hysteresis code returns the machine to `ALM_ARMED`; a code equal to the hysteresis code does not.
- R5: Every update with code <= shutdown threshold sets status bit 4+i.
- R6: A write to byte address 0x04 clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. An event set in the same cycle as its clear wins.
- R7: Status bits stay set until they are cleared through R6.
- R8: The interrupt-enable word at address 0x00 uses the status bit positions (alarm 0-2, shutdown 4-6, data-ready 8-10). `irq_o` is high exactly while some status bit and its enable are both 1.
- R9: The alarm word of channel i is at 0x10+4i, with the hot code in bits 27:16 and the hysteresis code in bits 11:0. The shutdown word is at 0x20+4i, with the shutdown code in bits 27:16. A new value applies to updates in later cycles.
- R10: Channels i >= `NUM_CH` never set status bits, and writes to their control words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_i | input | 36 | Latest codes, channel i in bits 12i+11:12i |
| code_vld_i | input | 3 | One-cycle update strobe per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Sticky status word; bits 31:11, 7 and 3 read 0 |
| irq_o | output | 1 | Interrupt, the OR of enabled status bits |

## Verification
The assertions assume that inputs are stable around the rising edge and that the address decode sees only aligned byte addresses. They assume the provenance check on channel 0 runs with at least one live channel. The stimulus changes every input on the falling edge only and uses only the documented word addresses. It also probes one channel beyond `NUM_CH` with hot codes and a control write, so the unused-channel rule is exercised rather than assumed.

// File: rtl/thm_pkg.sv
package thm_pkg;
    localparam int MAX_CH   = 3;
    localparam int CODE_W   = 12;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int STAT_W   = 11;
    localparam int ALM_LSB  = 0;
    localparam int SHD_LSB  = 4;
    localparam int RDY_LSB  = 8;
    localparam int HOT_LSB  = 16;
    localparam int HYS_LSB  = 0;

    localparam logic [ADDR_W-1:0] ADDR_INTEN = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 8'h04;
    localparam logic [ADDR_W-1:0] ADDR_ALM   = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_SHD   = 8'h20;
    localparam int                CH_STRIDE  = 4;

    typedef enum logic {
        ALM_ARMED   = 1'b0,
        ALM_TRIPPED = 1'b1
    } alm_state_e;

    function automatic logic [DATA_W-1:0] live_mask(input int n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < MAX_CH; k++) begin
            if (k < n) begin
                m[ALM_LSB+k] = 1'b1;
                m[SHD_LSB+k] = 1'b1;
                m[RDY_LSB+k] = 1'b1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/thm_cfg_regs.sv
module thm_cfg_regs
    import thm_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                wr_addr_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    output logic [MAX_CH-1:0][CODE_W-1:0]    hot_thr_o,
    output logic [MAX_CH-1:0][CODE_W-1:0]    hys_thr_o,
    output logic [MAX_CH-1:0][CODE_W-1:0]    shd_thr_o,
    output logic [STAT_W-1:0]                irq_en_o
);
    localparam logic [STAT_W-1:0] EN_MASK = STAT_W'(live_mask(MAX_CH));

    // Enable word keeps only the defined event positions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_o <= '0;
        end else if (wr_en_i && wr_addr_i == ADDR_INTEN) begin
            irq_en_o <= wr_data_i[STAT_W-1:0] & EN_MASK;
        end
    end

    genvar i;
    generate
        for (i = 0; i < MAX_CH; i++) begin : g_ch
            localparam logic [ADDR_W-1:0] A_ALM = ADDR_ALM + ADDR_W'(i * CH_STRIDE);
            localparam logic [ADDR_W-1:0] A_SHD = ADDR_SHD + ADDR_W'(i * CH_STRIDE);
            if (i < NUM_CH) begin : g_live
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        hot_thr_o[i] <= '0;
                        hys_thr_o[i] <= '0;
                    end else if (wr_en_i && wr_addr_i == A_ALM) begin
                        hot_thr_o[i] <= wr_data_i[HOT_LSB +: CODE_W];
                        hys_thr_o[i] <= wr_data_i[HYS_LSB +: CODE_W];
                    end
                end
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        shd_thr_o[i] <= '0;
                    end else if (wr_en_i && wr_addr_i == A_SHD) begin
                        shd_thr_o[i] <= wr_data_i[HOT_LSB +: CODE_W];
                    end
                end
            end else begin : g_dead
                assign hot_thr_o[i] = '0;
                assign hys_thr_o[i] = '0;
                assign shd_thr_o[i] = '0;
            end
        end
    endgenerate

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data_i[DATA_W-1:HOT_LSB+CODE_W],
                              wr_data_i[HOT_LSB-1:CODE_W]};
endmodule

// File: rtl/thm_alarm_fsm.sv
module thm_alarm_fsm
    import thm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CODE_W-1:0] hot_thr_i,
    input  logic [CODE_W-1:0] hys_thr_i,
    output logic              alarm_evt_o
);
    alm_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ALM_ARMED;
        else        state_q <= state_d;
    end

    // Next state and event output
    always_comb begin
        state_d     = state_q;
        alarm_evt_o = 1'b0;
        unique case (state_q)
            ALM_ARMED: begin
                if (upd_i && code_i <= hot_thr_i) begin
                    alarm_evt_o = 1'b1;
                    state_d     = ALM_TRIPPED;
                end
            end
            ALM_TRIPPED: begin
                if (upd_i && code_i > hys_thr_i) begin
                    state_d = ALM_ARMED;
                end
            end
            default: state_d = ALM_ARMED;
        endcase
    end
endmodule

// File: rtl/thm_status.sv
module thm_status
    import thm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic              clr_en_i,
    input  logic [STAT_W-1:0] clr_bits_i,
    input  logic [STAT_W-1:0] irq_en_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] clr_mask;

    assign clr_mask = clr_en_i ? clr_bits_i : '0;

    // New events override a clear landing in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_mask) | set_i;
    end

    assign irq_o = |(status_o & irq_en_i);
endmodule

// File: rtl/thm_irq_unit.sv
module thm_irq_unit
    import thm_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [MAX_CH*CODE_W-1:0]   code_i,
    input  logic [MAX_CH-1:0]          code_vld_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    output logic [DATA_W-1:0]          status_o,
    output logic                       irq_o
);
    logic [MAX_CH-1:0][CODE_W-1:0] hot_thr, hys_thr, shd_thr;
    logic [STAT_W-1:0]             irq_en;
    logic [STAT_W-1:0]             set_vec;
    logic [STAT_W-1:0]             stat_q;
    logic [MAX_CH-1:0]             alm_evt, shd_evt, rdy_evt;
    logic                          clr_en;

    thm_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .hot_thr_o (hot_thr),
        .hys_thr_o (hys_thr),
        .shd_thr_o (shd_thr),
        .irq_en_o  (irq_en)
    );

    genvar i;
    generate
        for (i = 0; i < MAX_CH; i++) begin : g_ch
            if (i < NUM_CH) begin : g_live
                logic [CODE_W-1:0] code;
                assign code = code_i[i*CODE_W +: CODE_W];

                thm_alarm_fsm u_alm (
                    .clk         (clk),
                    .rst_n       (rst_n),
                    .upd_i       (code_vld_i[i]),
                    .code_i      (code),
                    .hot_thr_i   (hot_thr[i]),
                    .hys_thr_i   (hys_thr[i]),
                    .alarm_evt_o (alm_evt[i])
                );

                assign shd_evt[i] = code_vld_i[i] && (code <= shd_thr[i]);
                assign rdy_evt[i] = code_vld_i[i];
            end else begin : g_dead
                assign alm_evt[i] = 1'b0;
                assign shd_evt[i] = 1'b0;
                assign rdy_evt[i] = 1'b0;
                logic unused_ch;
                assign unused_ch = ^{code_i[i*CODE_W +: CODE_W], code_vld_i[i],
                                     hot_thr[i], hys_thr[i], shd_thr[i]};
            end
        end
    endgenerate

    always_comb begin
        set_vec = '0;
        for (int k = 0; k < MAX_CH; k++) begin
            set_vec[ALM_LSB+k] = alm_evt[k];
            set_vec[SHD_LSB+k] = shd_evt[k];
            set_vec[RDY_LSB+k] = rdy_evt[k];
        end
    end

    assign clr_en = wr_en_i && (wr_addr_i == ADDR_STAT);

    thm_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .clr_en_i   (clr_en),
        .clr_bits_i (wr_data_i[STAT_W-1:0]),
        .irq_en_i   (irq_en),
        .status_o   (stat_q),
        .irq_o      (irq_o)
    );

    assign status_o = {{(DATA_W-STAT_W){1'b0}}, stat_q};
endmodule

// File: rtl/thm_irq_chk.sv
module thm_irq_chk
    import thm_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic              upd0_i,
    input logic [DATA_W-1:0] status_o,
    input logic              irq_o
);
    localparam logic [DATA_W-1:0] LIVE = live_mask(NUM_CH);

    // R8
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == '0) |-> !irq_o);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_addr_i == ADDR_STAT) |=>
        ((status_o & $past(status_o)) == $past(status_o)));

    // R2
    data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd0_i |=> status_o[RDY_LSB]);

    // R3
    alarm_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[ALM_LSB]) |-> $past(upd0_i));

    // R10
    idle_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~LIVE) == '0);
endmodule

bind thm_irq_unit thm_irq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .upd0_i    (code_vld_i[0]),
    .status_o  (status_o),
    .irq_o     (irq_o)
);

// File: tb/sim_thm_irq_unit.sv
module sim_thm_irq_unit;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] code_i = '0;
    logic [2:0]  code_vld_i = '0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] status_o;
    logic        irq_o;

    always #10 clk = ~clk;

    thm_irq_unit #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .code_i(code_i), .code_vld_i(code_vld_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .status_o(status_o), .irq_o(irq_o)
    );

    typedef struct {
        int          due;
        logic [31:0] st;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc   = 0;
    int   total = 0;
    int   bad   = 0;
    bit   ended = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare due items away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (status_o !== e.st || irq_o !== e.irq) begin
                bad++;
                $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                         e.tag, status_o, irq_o, e.st, e.irq);
            end
        end
    end

    // Driver: one cycle of stimulus plus its expected result
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic [2:0] vld, input logic [11:0] c0,
                        input logic [11:0] c1, input logic [11:0] c2,
                        input logic [31:0] st, input logic ir, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en_i    = we;
        wr_addr_i  = a;
        wr_data_i  = d;
        code_vld_i = vld;
        code_i     = {c2, c1, c0};
        e.due = cyc + 1;
        e.st  = st;
        e.irq = ir;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (status_o !== 32'h0 || irq_o !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: status=%h irq=%b expected status=00000000 irq=0",
                     status_o, irq_o);
        end
        rst_n = 1'b1;
        step(0, 8'h00, 0, 3'b000, 0, 0, 0, 32'h0, 0, "R1 idle after reset");
        step(1, 8'h10, 32'h0300_0400, 0, 0, 0, 0, 32'h0, 0, "R9 alarm word ch0");
        step(1, 8'h20, 32'h0200_0000, 0, 0, 0, 0, 32'h0, 0, "R9 shutdown word ch0");
        step(1, 8'h14, 32'h0500_0600, 0, 0, 0, 0, 32'h0, 0, "R9 alarm word ch1");
        step(1, 8'h00, 32'h0000_0001, 0, 0, 0, 0, 32'h0, 0, "R8 enable alarm0");
        step(0, 0, 0, 3'b001, 12'h350, 0, 0, 32'h100, 0, "R2 data ready ch0, R8 masked");
        step(1, 8'h04, 32'h100, 0, 0, 0, 0, 32'h0, 0, "R6 clear data bit");
        step(0, 0, 0, 3'b001, 12'h300, 0, 0, 32'h101, 1, "R3 alarm at equal code");
        step(1, 8'h04, 32'h001, 0, 0, 0, 0, 32'h100, 0, "R6 clear only alarm bit");
        step(0, 0, 0, 3'b001, 12'h2F0, 0, 0, 32'h100, 0, "R4 no refire while tripped");
        step(0, 0, 0, 3'b001, 12'h400, 0, 0, 32'h100, 0, "R4 equal hyst keeps tripped");
        step(0, 0, 0, 3'b001, 12'h300, 0, 0, 32'h100, 0, "R4 still tripped");
        step(0, 0, 0, 3'b001, 12'h401, 0, 0, 32'h100, 0, "R4 release above hyst");
        step(0, 0, 0, 3'b001, 12'h300, 0, 0, 32'h101, 1, "R3 refire after release");
        step(1, 8'h04, 32'h101, 0, 0, 0, 0, 32'h0, 0, "R6 write back clears both");
        step(0, 0, 0, 3'b001, 12'h200, 0, 0, 32'h110, 0, "R5 shutdown at equal code");
        step(1, 8'h00, 32'h0000_0010, 0, 0, 0, 0, 32'h110, 1, "R8 enable shutdown0");
        step(1, 8'h04, 32'h010, 3'b001, 12'h100, 0, 0, 32'h110, 1, "R6 set wins over clear");
        step(0, 0, 0, 0, 0, 0, 0, 32'h110, 1, "R7 sticky hold");
        step(1, 8'h04, 32'h110, 0, 0, 0, 0, 32'h0, 0, "R6 clear all seen");
        step(0, 0, 0, 3'b010, 0, 12'h500, 0, 32'h202, 0, "R3 alarm ch1");
        step(0, 0, 0, 3'b100, 0, 0, 12'h000, 32'h202, 0, "R10 dead channel update");
        step(1, 8'h18, 32'h0FFF_0FFF, 0, 0, 0, 0, 32'h202, 0, "R10 dead channel write");
        step(0, 0, 0, 3'b100, 0, 0, 12'h000, 32'h202, 0, "R10 dead channel after write");
        step(0, 0, 0, 3'b011, 12'h500, 12'h700, 0, 32'h302, 0, "R2 two channels at once");
        step(1, 8'h04, 32'hFFFF_FFFF, 0, 0, 0, 0, 32'h0, 0, "R6 clear everything");
        step(1, 8'h00, 32'h0000_0700, 0, 0, 0, 0, 32'h0, 0, "R8 enable data ready");
        step(0, 0, 0, 3'b010, 0, 12'h4FF, 0, 32'h202, 1, "R4 ch1 rearmed then alarm");
        step(1, 8'h04, 32'h0, 0, 0, 0, 0, 32'h202, 1, "R6 zero write no effect");
        step(0, 0, 0, 0, 0, 0, 0, 32'h202, 1, "R7 hold with irq");
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (2000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end
endmodule